// File: doc/BRIEF.md
# Adder-Based Arithmetic Unit with Status Flags

This block is an 8-bit arithmetic unit built on one ripple-carry binary adder. It performs five operations: add, add with the stored carry, subtract, subtract with the stored borrow, and compare. It keeps an 8-bit result register and six registered status flags, all derived from the adder's own carries and sum bits. Subtraction reuses the same adder by inverting the second operand and forcing the carry-in.

A single carry flip-flop does two jobs. It supplies the carry-in for the carry-using operations, and it captures the carry-out of every operation. After subtract-type operations it holds a borrow rather than a raw carry. A combinational signed-less output, formed from the stored sign and overflow flags, lets the surrounding datapath make a signed comparison after a compare operation.

The block updates only on a clock edge where the load enable is high and the operation code is valid. Compare updates the flags but leaves the result register alone.

Top module: `adder_flag_alu`

## Requirements
- R1: With op = 3'd0 (add), the result becomes (a + b) mod 256, and carry_flag becomes the carry out of bit 7.
- R2: With op = 3'd1 (add with carry), the result becomes (a + b + carry_flag) mod 256, using the stored carry_flag as carry-in. carry_flag becomes the new carry out of bit 7.
- R3: With op = 3'd2 (subtract), the result becomes (a - b) mod 256. carry_flag becomes 1 exactly when a < b as unsigned numbers, so it acts as a borrow.
- R4: With op = 3'd3 (subtract with borrow), the result becomes (a - b - carry_flag) mod 256. carry_flag becomes 1 exactly when a < b + old carry_flag.
- R5: With op = 3'd4 (compare), every flag updates exactly as for a subtract, and the result register keeps its previous value.
- R6: aux_flag is the carry out of bit 3 for the add operations. For the subtract and compare operations it is the borrow out of the low nibble, which is 1 when (a mod 16) < (b mod 16) + borrow-in.
- R7: sign_flag is bit 7 of the adder output. zero_flag is 1 when all eight adder output bits are 0, including when a carry or borrow also occurred.
- R8: parity_flag is 1 when the adder output has an even number of one bits. An all-zero output counts as even.
- R9: ovf_flag is 1 when the two's-complement outcome is outside -128..127. This is the XOR of the carry into bit 7 and the carry out of bit 7.
- R10: signed_less equals sign_flag XOR ovf_flag at all times, taken from the stored flags with no extra register.
- R11: When load_en is 0, or op is 3'd5, 3'd6 or 3'd7, the result and all flags keep their values.
- R12: A synchronous reset (rst high at a rising edge) clears the result and all six flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Update enable for result and flags |
| op | input | 3 | Operation select (0 add, 1 add-carry, 2 sub, 3 sub-borrow, 4 compare) |
| a | input | 8 | First operand |
| b | input | 8 | Second operand |
| result | output | 8 | Registered result |
| carry_flag | output | 1 | Carry / borrow flag |
| aux_flag | output | 1 | Low-nibble carry / borrow flag |
| sign_flag | output | 1 | Sign flag |
| zero_flag | output | 1 | Zero flag |
| parity_flag | output | 1 | Even-parity flag |
| ovf_flag | output | 1 | Signed overflow flag |
| signed_less | output | 1 | Combinational signed less-than |

## Verification
The hardest cases to reach are the carry-chained operations that start from a specific stored carry. Examples are an add-with-carry or a subtract-with-borrow that runs with the flag set, and a borrow that ripples through a zero difference. The carry can only be set by an earlier operation, so the stimulus first runs an add or subtract chosen to leave the flag in the needed state. It then issues the chained operation, for example 0xFF + 0x01 followed by add-with-carry, or 0x00 - 0x01 followed by subtract-with-borrow. The stimulus also covers a zero result that carries out (0x80 + 0x80), and compare steps placed between stores to show that the result is kept. Long random runs then mix all eight codes and a toggling load enable, so the stored carry takes both values before every chained operation.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_CMP = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic cf;
    logic af;
    logic sf;
    logic zf;
    logic pf;
    logic of;
  } alu_flags_t;

  // one-bit full adder, sum output
  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  // one-bit full adder, carry output
  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (ci & (x ^ y));
  endfunction

endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] b_in,
  input  logic         cf_q,
  output logic [W-1:0] b_eff,
  output logic         cin,
  output logic         sub_mode,
  output logic         op_valid,
  output logic         is_cmp
);
  always_comb begin
    b_eff    = b_in;
    cin      = 1'b0;
    sub_mode = 1'b0;
    op_valid = 1'b1;
    is_cmp   = 1'b0;
    unique case (op)
      OP_ADD: cin = 1'b0;
      OP_ADC: cin = cf_q;
      OP_SUB: begin
        sub_mode = 1'b1;
        b_eff    = ~b_in;
        cin      = 1'b1;
      end
      OP_SBB: begin
        sub_mode = 1'b1;
        b_eff    = ~b_in;
        cin      = ~cf_q;
      end
      OP_CMP: begin
        sub_mode = 1'b1;
        b_eff    = ~b_in;
        cin      = 1'b1;
        is_cmp   = 1'b1;
      end
      default: op_valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder
  import alu_pkg::*;
#(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_nib,
  output logic         c_top_in,
  output logic         c_top_out
);
  logic [W:0] c;
  assign c[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]   = fa_sum(x[i], y[i], c[i]);
    assign c[i+1]   = fa_carry(x[i], y[i], c[i]);
  end

  assign c_nib     = c[NIB];
  assign c_top_in  = c[W-1];
  assign c_top_out = c[W];
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] sum,
  input  logic         c_nib,
  input  logic         c_top_in,
  input  logic         c_top_out,
  input  logic         sub_mode,
  output alu_flags_t   flags_d
);
  always_comb begin
    flags_d.cf = c_top_out ^ sub_mode;   // borrow sense after subtract
    flags_d.af = c_nib ^ sub_mode;
    flags_d.sf = sum[W-1];
    flags_d.zf = ~|sum;
    flags_d.pf = ~^sum;
    flags_d.of = c_top_in ^ c_top_out;
  end
endmodule

// File: rtl/adder_flag_alu.sv
module adder_flag_alu
  import alu_pkg::*;
#(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic         carry_flag,
  output logic         aux_flag,
  output logic         sign_flag,
  output logic         zero_flag,
  output logic         parity_flag,
  output logic         ovf_flag,
  output logic         signed_less
);
  logic [W-1:0] result_q;
  alu_flags_t   flags_q;
  alu_flags_t   flags_d;

  // internal events, named for the checker
  logic [W-1:0] b_eff;
  logic         adder_cin;
  logic         sub_mode;
  logic         op_valid;
  logic         is_cmp;
  logic [W-1:0] adder_sum;
  logic         adder_c_nib;
  logic         adder_c_top_in;
  logic         adder_c_top_out;
  logic         upd_en;

  alu_operand_prep #(.W(W)) prep_i (
    .op       (op),
    .b_in     (b),
    .cf_q     (flags_q.cf),
    .b_eff    (b_eff),
    .cin      (adder_cin),
    .sub_mode (sub_mode),
    .op_valid (op_valid),
    .is_cmp   (is_cmp)
  );

  alu_ripple_adder #(.W(W), .NIB(NIB)) add_i (
    .x         (a),
    .y         (b_eff),
    .cin       (adder_cin),
    .sum       (adder_sum),
    .c_nib     (adder_c_nib),
    .c_top_in  (adder_c_top_in),
    .c_top_out (adder_c_top_out)
  );

  alu_flag_gen #(.W(W)) flg_i (
    .sum       (adder_sum),
    .c_nib     (adder_c_nib),
    .c_top_in  (adder_c_top_in),
    .c_top_out (adder_c_top_out),
    .sub_mode  (sub_mode),
    .flags_d   (flags_d)
  );

  assign upd_en = load_en & op_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      flags_q  <= '0;
    end else if (upd_en) begin
      flags_q <= flags_d;
      if (!is_cmp) result_q <= adder_sum;
    end
  end

  assign result      = result_q;
  assign carry_flag  = flags_q.cf;
  assign aux_flag    = flags_q.af;
  assign sign_flag   = flags_q.sf;
  assign zero_flag   = flags_q.zf;
  assign parity_flag = flags_q.pf;
  assign ovf_flag    = flags_q.of;
  assign signed_less = flags_q.sf ^ flags_q.of;
endmodule

// File: rtl/adder_flag_alu_chk.sv
module adder_flag_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         load_en,
  input logic [2:0]   op,
  input logic [W-1:0] result,
  input logic         carry_flag,
  input logic         aux_flag,
  input logic         sign_flag,
  input logic         zero_flag,
  input logic         parity_flag,
  input logic         ovf_flag,
  input logic [W-1:0] sum_w,
  input logic         c_nib,
  input logic         c_top_in,
  input logic         c_top_out,
  input logic         sub_mode
);
  logic [5:0] flag_vec;
  logic       live_op;
  assign flag_vec = {carry_flag, aux_flag, sign_flag, zero_flag, parity_flag, ovf_flag};
  assign live_op  = load_en && (op <= 3'd4);

  assert_reset_clears_R12: assert property (@(posedge clk)
    rst |=> (result == '0) && (flag_vec == 6'd0));

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!load_en || op > 3'd4) |=> $stable(result) && $stable(flag_vec));

  assert_cmp_keeps_result_R5: assert property (@(posedge clk) disable iff (rst)
    (load_en && op == 3'd4) |=> $stable(result));

  assert_carry_capture_R1: assert property (@(posedge clk) disable iff (rst)
    live_op |=> carry_flag == $past(c_top_out ^ sub_mode));

  assert_nibble_carry_R6: assert property (@(posedge clk) disable iff (rst)
    live_op |=> aux_flag == $past(c_nib ^ sub_mode));

  assert_sign_zero_R7: assert property (@(posedge clk) disable iff (rst)
    live_op |=> (sign_flag == $past(sum_w[W-1])) && (zero_flag == ($past(sum_w) == '0)));

  assert_parity_R8: assert property (@(posedge clk) disable iff (rst)
    live_op |=> parity_flag == !$countones($past(sum_w))[0]);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    live_op |=> ovf_flag == $past(c_top_in ^ c_top_out));
endmodule

bind adder_flag_alu adder_flag_alu_chk #(.W(W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .load_en     (load_en),
  .op          (op),
  .result      (result),
  .carry_flag  (carry_flag),
  .aux_flag    (aux_flag),
  .sign_flag   (sign_flag),
  .zero_flag   (zero_flag),
  .parity_flag (parity_flag),
  .ovf_flag    (ovf_flag),
  .sum_w       (adder_sum),
  .c_nib       (adder_c_nib),
  .c_top_in    (adder_c_top_in),
  .c_top_out   (adder_c_top_out),
  .sub_mode    (sub_mode)
);

// File: tb/adder_flag_alu_tb_top.sv
module adder_flag_alu_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_en = 1'b0;
  logic [2:0] op = 3'd0;
  logic [7:0] a = 8'd0;
  logic [7:0] b = 8'd0;
  logic [7:0] result;
  logic carry_flag, aux_flag, sign_flag, zero_flag, parity_flag, ovf_flag, signed_less;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;  // 50 MHz

  adder_flag_alu dut_i (
    .clk(clk), .rst(rst), .load_en(load_en), .op(op), .a(a), .b(b),
    .result(result), .carry_flag(carry_flag), .aux_flag(aux_flag),
    .sign_flag(sign_flag), .zero_flag(zero_flag), .parity_flag(parity_flag),
    .ovf_flag(ovf_flag), .signed_less(signed_less)
  );

  // behavioural reference state
  int    m_res = 0;
  bit    m_cf, m_af, m_sf, m_zf, m_pf, m_of;
  string m_tag = "R12";

  always @(posedge clk) begin
    int ua, ub, cin, full, r, sa, sb, sres;
    if (rst) begin
      m_res = 0; m_cf = 0; m_af = 0; m_sf = 0; m_zf = 0; m_pf = 0; m_of = 0;
      m_tag = "R12";
    end else if (load_en && op <= 3'd4) begin
      ua = int'(a); ub = int'(b);
      sa = (ua >= 128) ? ua - 256 : ua;
      sb = (ub >= 128) ? ub - 256 : ub;
      if (op < 3'd2) begin
        cin  = (op == 3'd1) ? int'(m_cf) : 0;
        full = ua + ub + cin;
        m_cf = full > 255;
        m_af = ((ua % 16) + (ub % 16) + cin) > 15;
        sres = sa + sb + cin;
      end else begin
        cin  = (op == 3'd3) ? int'(m_cf) : 0;
        full = ua - ub - cin;
        m_cf = full < 0;
        m_af = (ua % 16) < ((ub % 16) + cin);
        sres = sa - sb - cin;
      end
      r    = (full + 512) % 256;
      m_sf = r >= 128;
      m_zf = r == 0;
      m_pf = ($countones(r[7:0]) % 2) == 0;
      m_of = (sres > 127) || (sres < -128);
      if (op != 3'd4) m_res = r;
      case (op)
        3'd0: m_tag = "R1";
        3'd1: m_tag = "R2";
        3'd2: m_tag = "R3";
        3'd3: m_tag = "R4";
        default: m_tag = "R5";
      endcase
    end else begin
      m_tag = "R11";
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string ftag(input string dflt);
    if (m_tag == "R11" || m_tag == "R12") return m_tag;
    return dflt;
  endfunction

  task automatic compare_all();
    chk(m_tag, "result", int'(result), m_res);
    chk(m_tag, "carry", int'(carry_flag), int'(m_cf));
    chk(ftag("R6"), "aux", int'(aux_flag), int'(m_af));
    chk(ftag("R7"), "sign", int'(sign_flag), int'(m_sf));
    chk(ftag("R7"), "zero", int'(zero_flag), int'(m_zf));
    chk(ftag("R8"), "parity", int'(parity_flag), int'(m_pf));
    chk(ftag("R9"), "ovf", int'(ovf_flag), int'(m_of));
    chk("R10", "signed_less", int'(signed_less), int'(m_sf ^ m_of));
  endtask

  // check last edge's outcome, then drive the next inputs
  task automatic step(input logic [2:0] o, input logic [7:0] x, input logic [7:0] y, input logic le);
    @(negedge clk);
    compare_all();
    op = o; a = x; b = y; load_en = le;
  endtask

  initial begin
    rst = 1'b1;
    step(3'd0, 8'h12, 8'h34, 1'b1);       // held in reset: R12
    step(3'd0, 8'h12, 8'h34, 1'b1);
    rst = 1'b0;
    step(3'd0, 8'h80, 8'h80, 1'b1);       // R1/R7: zero with carry, overflow
    step(3'd0, 8'h7F, 8'h01, 1'b1);       // R9/R6: signed overflow, nibble carry
    step(3'd0, 8'hFF, 8'h01, 1'b1);       // sets carry
    step(3'd1, 8'h10, 8'h20, 1'b1);       // R2 with carry set -> 0x31
    step(3'd1, 8'h10, 8'h20, 1'b1);       // R2 with carry clear
    step(3'd2, 8'h00, 8'h01, 1'b1);       // R3 borrow
    step(3'd3, 8'h05, 8'h05, 1'b1);       // R4 with borrow in -> 0xFF
    step(3'd3, 8'h05, 8'h05, 1'b1);       // R4 borrow again
    step(3'd2, 8'h80, 8'h01, 1'b1);       // R9 subtract overflow
    step(3'd4, 8'h10, 8'h20, 1'b1);       // R5 compare, result kept
    step(3'd4, 8'h20, 8'h20, 1'b1);       // R5 equal -> zero
    step(3'd5, 8'hAA, 8'h55, 1'b1);       // R11 unused code
    step(3'd0, 8'hAA, 8'h55, 1'b0);       // R11 load disabled
    step(3'd7, 8'h01, 8'h01, 1'b1);       // R11
    step(3'd2, 8'h03, 8'h01, 1'b1);       // R8 parity
    for (int i = 0; i < 4000; i++) begin
      if (i == 2000) rst = 1'b1;
      if (i == 2002) rst = 1'b0;
      step(3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom), ($urandom_range(0, 7) != 0));
    end
    step(3'd0, 8'h00, 8'h00, 1'b0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule